// File: doc/BRIEF.md
# Memory Frequency Switch Sequencer

This block runs the hardware side of a DRAM clock-rate change. Software programs a control word with the switch mode, a clock-bypass option, a pad-hold option and a timing double-buffer enable, and then sets a start bit. The sequencer waits until every bus master is ready to be paused. It then holds the pads if asked to, and asks the clock generator to switch over a request/acknowledge handshake. When the switch is acknowledged, the refresh-timing value held in a shadow register is copied into the live register in one step. The sequencer then releases the pads and clears start, which is the completion flag that software polls.

While double buffering is on, writes to the refresh-timing register land only in the shadow copy. When buffering is off, the same writes take effect on the live value at once. If the clock acknowledge does not arrive within a programmable number of cycles, the sequence is abandoned. In that case the live timing is left untouched, a sticky error flag is raised and start is cleared.

Top module: `freq_switch_seq`

## Requirements
- R1: The control register is at address 0. Bit 0 is start, bit 1 is mode (0 = dynamic switch, 1 = alternate), bit 4 is bypass, bit 13 is pad-hold enable and bit 15 is the double-buffer enable. All other bits read back as 0. Output `clkCfg` presents {bypass, mode}.
- R2: Writing 1 to start while the block is idle launches a sequence. Start reads 1 for as long as the sequence runs, and the hardware clears it when the sequence ends.
- R3: The ready mask is at address 1 and resets to 0. Master i counts as ready when `mastReady[i]` is 1 or mask bit i is 1. `clkSwReq` never rises until all masters have been ready.
- R4: When pad-hold is enabled, `padHold` is high from the step after the ready wait until the release step, and it covers every cycle in which `clkSwReq` is high. When pad-hold is disabled, `padHold` stays low. `padHold` is low once start has cleared.
- R5: `clkSwReq` stays high until `clkSwAck` is seen or the timeout expires. `clkCfg` is valid while the request is high.
- R6: The refresh-timing register is at address 2. With buffering on, a write to it changes only the shadow copy, which is what address 2 reads back. The live outputs do not change.
- R7: After an acknowledged switch, the live value equals the shadow. `refiOut` shows bits 31:16 of the live value (the refresh interval, in units of 32 controller clocks). `rfcOut` shows bits 9:0 of the live value (the refresh cycle time, in controller clocks).
- R8: With buffering off, a refresh-timing write updates the live outputs on the next clock edge.
- R9: Any control-register write made while a sequence is in progress is ignored.
- R10: The timeout limit L is at address 3 and resets to 1000. If no acknowledge arrives, `clkSwReq` is high for exactly L+1 cycles and the sequence then aborts. On abort, the shadow is not committed, start clears, and status bit 0 at address 4 is set. That bit stays set across later runs until 1 is written to status bit 0.
- R11: After reset, the control, mask and status registers read 0, the live timing is 0, and `clkSwReq` and `padHold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data (combinational) |
| mastReady | input | NUM_MASTERS | Per-master ready indications |
| clkSwReq | output | 1 | Clock switch request |
| clkSwAck | input | 1 | Clock switch acknowledge |
| clkCfg | output | 2 | {bypass, mode} for the clock generator |
| padHold | output | 1 | DRAM pad hold |
| refiOut | output | 16 | Live refresh interval field |
| rfcOut | output | 10 | Live refresh cycle time field |

## Verification
A sequencer stuck in its ready wait shows up as start reading 1 with no `clkSwReq`. A skipped or early commit shows up on `refiOut`/`rfcOut` either before the acknowledge or not at all after it, within two cycles of the handshake. A broken timeout counter shows up as a request pulse whose length differs from L+1, or as a status bit that does not set. A mis-decoded buffer enable shows up on the live outputs one cycle after a timing write.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_REFR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam int B_START = 0;
  localparam int B_MODE  = 1;
  localparam int B_BYP   = 4;
  localparam int B_HOLD  = 13;
  localparam int B_BUF   = 15;
  localparam int REFI_LSB = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_WAITRDY, S_HOLD, S_REQ, S_WAITACK,
    S_COMMIT, S_ABORT, S_RELEASE, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic busy;
    logic commit;
    logic setErr;
    logic clrStart;
  } seq_strb_t;
endpackage

// File: rtl/fsw_ctrl.sv
module fsw_ctrl #(
  parameter int TMO_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startBit,
  input  logic                holdEn,
  input  logic                allReady,
  input  logic                clkSwAck,
  input  logic [TMO_W-1:0]    limit,
  output logic                clkSwReq,
  output logic                padHold,
  output fsw_pkg::seq_strb_t  strb
);
  import fsw_pkg::*;

  seq_state_t state, nxt;
  logic [TMO_W-1:0] waitCnt;
  logic timeUp;

  assign timeUp = ({1'b0, waitCnt} + 1'b1) >= {1'b0, limit};

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:    if (startBit) nxt = S_WAITRDY;
      S_WAITRDY: if (allReady) nxt = S_HOLD;
      S_HOLD:    nxt = S_REQ;
      S_REQ:     nxt = S_WAITACK;
      S_WAITACK: begin
        if (clkSwAck)    nxt = S_COMMIT;
        else if (timeUp) nxt = S_ABORT;
      end
      S_COMMIT:  nxt = S_RELEASE;
      S_ABORT:   nxt = S_RELEASE;
      S_RELEASE: nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      state <= nxt;
      if (state == S_REQ)
        waitCnt <= '0;
      else if (state == S_WAITACK && !timeUp)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  assign clkSwReq = (state == S_REQ) || (state == S_WAITACK);
  assign padHold  = holdEn && (state == S_HOLD || state == S_REQ ||
                    state == S_WAITACK || state == S_COMMIT || state == S_ABORT);

  assign strb.busy     = (state != S_IDLE) || startBit;
  assign strb.commit   = (state == S_COMMIT);
  assign strb.setErr   = (state == S_ABORT);
  assign strb.clrStart = (state == S_DONE);
endmodule

// File: rtl/fsw_datapath.sv
module fsw_datapath #(
  parameter int NUM_MASTERS = 8,
  parameter int TMO_W       = 16,
  parameter int TMO_RESET   = 1000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [fsw_pkg::ADDR_W-1:0]    wrAddr,
  input  logic [fsw_pkg::DATA_W-1:0]    wrData,
  input  logic [fsw_pkg::ADDR_W-1:0]    rdAddr,
  output logic [fsw_pkg::DATA_W-1:0]    rdData,
  input  logic [NUM_MASTERS-1:0]        mastReady,
  input  fsw_pkg::seq_strb_t            strb,
  output logic                          startBit,
  output logic                          holdEn,
  output logic                          bufEn,
  output logic                          allReady,
  output logic                          errFlag,
  output logic [TMO_W-1:0]              limit,
  output logic [1:0]                    clkCfg,
  output logic [fsw_pkg::DATA_W-1:0]    liveRef
);
  import fsw_pkg::*;

  logic modeBit, bypBit;
  logic [NUM_MASTERS-1:0] maskReg, readyVec;
  logic [DATA_W-1:0] shadowRef;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MASTERS; gi++) begin : g_rdy
      assign readyVec[gi] = mastReady[gi] | maskReg[gi];
    end
  endgenerate
  assign allReady = &readyVec;

  logic wrCtrl, wrMask, wrRef, wrLim, wrStat;
  assign wrCtrl = wrEn && (wrAddr == A_CTRL) && !strb.busy;
  assign wrMask = wrEn && (wrAddr == A_MASK);
  assign wrRef  = wrEn && (wrAddr == A_REFR);
  assign wrLim  = wrEn && (wrAddr == A_LIMIT);
  assign wrStat = wrEn && (wrAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit <= 1'b0;
      modeBit  <= 1'b0;
      bypBit   <= 1'b0;
      holdEn   <= 1'b0;
      bufEn    <= 1'b0;
    end else if (wrCtrl) begin
      startBit <= wrData[B_START];
      modeBit  <= wrData[B_MODE];
      bypBit   <= wrData[B_BYP];
      holdEn   <= wrData[B_HOLD];
      bufEn    <= wrData[B_BUF];
    end else if (strb.clrStart) begin
      startBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      limit     <= TMO_W'(TMO_RESET);
      shadowRef <= '0;
      liveRef   <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (wrMask) maskReg <= wrData[NUM_MASTERS-1:0];
      if (wrLim)  limit   <= wrData[TMO_W-1:0];
      if (wrRef)  shadowRef <= wrData;
      if (wrRef && !bufEn)  liveRef <= wrData;
      else if (strb.commit) liveRef <= shadowRef;
      if (strb.setErr)             errFlag <= 1'b1;
      else if (wrStat && wrData[0]) errFlag <= 1'b0;
    end
  end

  assign clkCfg = {bypBit, modeBit};

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL: begin
        rdData[B_START] = startBit;
        rdData[B_MODE]  = modeBit;
        rdData[B_BYP]   = bypBit;
        rdData[B_HOLD]  = holdEn;
        rdData[B_BUF]   = bufEn;
      end
      A_MASK:  rdData[NUM_MASTERS-1:0] = maskReg;
      A_REFR:  rdData = shadowRef;
      A_LIMIT: rdData[TMO_W-1:0] = limit;
      A_STAT:  rdData[0] = errFlag;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/freq_switch_seq.sv
module freq_switch_seq #(
  parameter int NUM_MASTERS = 8,
  parameter int TMO_W       = 16,
  parameter int TMO_RESET   = 1000,
  parameter int RFC_W       = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [2:0]                wrAddr,
  input  logic [31:0]               wrData,
  input  logic [2:0]                rdAddr,
  output logic [31:0]               rdData,
  input  logic [NUM_MASTERS-1:0]    mastReady,
  output logic                      clkSwReq,
  input  logic                      clkSwAck,
  output logic [1:0]                clkCfg,
  output logic                      padHold,
  output logic [15:0]               refiOut,
  output logic [RFC_W-1:0]          rfcOut
);
  import fsw_pkg::*;

  seq_strb_t strb;
  logic startBit, holdEn, bufEn, allReady, errFlag;
  logic [TMO_W-1:0] limit;
  logic [DATA_W-1:0] liveRef;

  fsw_datapath #(.NUM_MASTERS(NUM_MASTERS), .TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .mastReady(mastReady), .strb(strb),
    .startBit(startBit), .holdEn(holdEn), .bufEn(bufEn), .allReady(allReady),
    .errFlag(errFlag), .limit(limit), .clkCfg(clkCfg), .liveRef(liveRef)
  );

  fsw_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .holdEn(holdEn),
    .allReady(allReady), .clkSwAck(clkSwAck), .limit(limit),
    .clkSwReq(clkSwReq), .padHold(padHold), .strb(strb)
  );

  assign refiOut = liveRef[REFI_LSB +: 16];
  assign rfcOut  = liveRef[RFC_W-1:0];
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
  parameter int RFC_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               clkSwReq,
  input logic               clkSwAck,
  input logic               padHold,
  input logic               holdEn,
  input logic               allReady,
  input logic               startBit,
  input logic               errFlag,
  input logic               bufEn,
  input logic               wrEn,
  input logic [2:0]         wrAddr,
  input fsw_pkg::seq_strb_t strb,
  input logic [15:0]        refiOut,
  input logic [RFC_W-1:0]   rfcOut
);
  import fsw_pkg::*;

  assert_req_after_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSwReq) |-> $past(allReady, 2));

  assert_hold_covers_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkSwReq && holdEn) |-> padHold);

  assert_no_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !holdEn |-> !padHold);

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> (!clkSwReq && !padHold));

  assert_commit_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(clkSwAck));

  assert_live_change_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({refiOut, rfcOut}) |->
      ($past(strb.commit) || $past(wrEn && wrAddr == A_REFR && !bufEn)));

  assert_err_on_timeout_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($past(clkSwReq, 2) && !$past(clkSwAck, 2)));
endmodule

bind freq_switch_seq fsw_checker #(.RFC_W(RFC_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkSwReq(clkSwReq), .clkSwAck(clkSwAck),
  .padHold(padHold), .holdEn(holdEn), .allReady(allReady),
  .startBit(startBit), .errFlag(errFlag), .bufEn(bufEn), .wrEn(wrEn),
  .wrAddr(wrAddr), .strb(strb), .refiOut(refiOut), .rfcOut(rfcOut)
);

// File: tb/sim_freq_switch_seq.sv
`timescale 1ns/1ps
module sim_freq_switch_seq;
  logic clk = 0, rstN = 0, wrEn = 0, clkSwAck = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, rdData;
  logic [7:0] mastReady = 0;
  logic clkSwReq, padHold;
  logic [1:0] clkCfg;
  logic [15:0] refiOut;
  logic [9:0] rfcOut;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  freq_switch_seq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .mastReady(mastReady),
    .clkSwReq(clkSwReq), .clkSwAck(clkSwAck), .clkCfg(clkCfg),
    .padHold(padHold), .refiOut(refiOut), .rfcOut(rfcOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic waitReq(output bit seen);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (clkSwReq) seen = 1;
    end
  endtask

  task automatic waitDone(output int reqCycles);
    logic [31:0] v;
    reqCycles = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clkSwReq) reqCycles++;
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R11 ctrl", v, 0);
    rd(3'd1, v); chk("R11 mask", v, 0);
    rd(3'd4, v); chk("R11 status", v, 0);
    rd(3'd3, v); chk("R10 limit reset", v, 1000);
    chk("R11 req/hold", {clkSwReq, padHold}, 0);
    chk("R11 live", {refiOut, 6'b0, rfcOut}, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, v); chk("R1 ctrl readback", v, 32'h0000_A012);
    chk("R1 clkCfg", clkCfg, 2'b11);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_unbuf();
    wr(3'd2, 32'h0030_0049);
    chk("R8 refi immediate", refiOut, 16'h0030);
    chk("R7 rfc field", rfcOut, 10'h049);
    wr(3'd2, 32'h0012_0FFF);
    chk("R7 rfc low bits only", rfcOut, 10'h3FF);
    wr(3'd2, 32'h0030_0049);
  endtask

  task automatic t_buffered();
    logic [31:0] v;
    wr(3'd0, 32'h0000_8000);
    wr(3'd2, 32'h0061_0092);
    chk("R6 live unchanged", refiOut, 16'h0030);
    rd(3'd2, v); chk("R6 shadow readback", v, 32'h0061_0092);
  endtask

  task automatic t_gated_switch();
    logic [31:0] v; bit seen; int n; bit reqWhileWait;
    mastReady = 8'h7F;
    wr(3'd0, 32'h0000_A013);
    reqWhileWait = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clkSwReq) reqWhileWait = 1;
    end
    chk("R3 no req while master not ready", reqWhileWait, 0);
    rd(3'd0, v); chk("R2 start held", v[0], 1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R9 ctrl write ignored", v, 32'h0000_A013);
    wr(3'd1, 32'h0000_0080);
    waitReq(seen);
    chk("R3 req after mask", seen, 1);
    chk("R4 pad hold during req", padHold, 1);
    chk("R5 clkCfg with req", clkCfg, 2'b11);
    repeat (3) @(negedge clk);
    chk("R5 req held w/o ack", clkSwReq, 1);
    chk("R6 no commit before ack", refiOut, 16'h0030);
    clkSwAck = 1;
    while (clkSwReq) @(negedge clk);
    clkSwAck = 0;
    waitDone(n);
    rd(3'd0, v); chk("R2 start cleared", v[0], 0);
    chk("R7 commit refi", refiOut, 16'h0061);
    chk("R7 commit rfc", rfcOut, 10'h092);
    chk("R4 hold released", padHold, 0);
    rd(3'd4, v); chk("R10 no error on ack", v, 0);
  endtask

  task automatic t_no_hold();
    bit seen; bit holdSeen; int n;
    wr(3'd1, 32'h0000_00FF);
    wr(3'd0, 32'h0000_8000);
    wr(3'd2, 32'h0011_0022);
    wr(3'd0, 32'h0000_8001);
    holdSeen = 0;
    waitReq(seen);
    if (padHold) holdSeen = 1;
    clkSwAck = 1;
    while (clkSwReq) begin @(negedge clk); if (padHold) holdSeen = 1; end
    clkSwAck = 0;
    waitDone(n);
    chk("R4 no hold when disabled", holdSeen, 0);
    chk("R7 second commit", refiOut, 16'h0011);
  endtask

  task automatic t_timeout();
    logic [31:0] v; int n;
    wr(3'd3, 32'd5);
    wr(3'd2, 32'h0077_0055);
    wr(3'd0, 32'h0000_8001);
    waitDone(n);
    chk("R10 req cycles L+1", n, 6);
    rd(3'd4, v); chk("R10 error set", v, 1);
    rd(3'd0, v); chk("R10 start cleared", v[0], 0);
    chk("R10 no commit on abort", refiOut, 16'h0011);
    chk("R10 rfc kept", rfcOut, 10'h022);
  endtask

  task automatic t_sticky();
    logic [31:0] v; bit seen; int n;
    wr(3'd0, 32'h0000_8001);
    waitReq(seen);
    clkSwAck = 1;
    while (clkSwReq) @(negedge clk);
    clkSwAck = 0;
    waitDone(n);
    rd(3'd4, v); chk("R10 error sticky", v, 1);
    chk("R7 commit after retry", refiOut, 16'h0077);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R10 error cleared", v, 0);
  endtask

  task automatic t_unbuf_after();
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0005_0006);
    chk("R8 immediate after buffer off", {refiOut, 6'b0, rfcOut}, 32'h0005_0006);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_unbuf();
    t_buffered();
    t_gated_switch();
    t_no_hold();
    t_timeout();
    t_sticky();
    t_unbuf_after();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule